// File: doc/BRIEF.md
# Serial-Loaded Mapper Register File

This block sits on the cartridge side of a CPU bus and holds four 5-bit configuration registers. A CPU write into the block's window carries only one useful data bit. Each accepted write either aborts the current load or shifts that bit into a 5-bit staging register. When the fifth bit arrives, the staged value is committed to one of four registers, and two address bits sampled on that fifth write choose which one.

Read-modify-write instructions on the CPU side put two writes on consecutive cycles: a dummy write of the old value, then the real one. The block keeps a small elapsed-cycle counter and drops any write that lands on the cycle right after another write. A dropped write still restarts the counter. The four register values are brought out directly so that downstream bank-mapping logic can decode them.

Top module: `serial_reg_loader`

## Requirements
- R1: While the asynchronous active-low reset is asserted, the control register reads 0x0C and the other three registers read 0. The staging register and the bit counter are cleared.
- R2: Bits arrive least significant first. Each accepted shifting write moves the staging register right by one place and loads data bit 0 into staging bit 4.
- R3: The fifth accepted shifting write commits the staged value in the next clock cycle. The target is chosen by `sel_i` as sampled on that fifth write: 00 selects control, 01 selects character bank A, 10 selects character bank B, and 11 selects program bank.
- R4: Fewer than five accepted shifting writes leave all four registers unchanged.
- R5: An accepted write with data bit 7 set is an abort write. It clears the staging register and the bit counter, ORs 0x0C into the control register, and leaves control bits 4, 1 and 0 and the other registers unchanged. It commits nothing, whatever its bit 0 holds.
- R6: A write on the clock cycle directly after another write is ignored. It does not shift, abort or commit.
- R7: Every write restarts the gap timer, including an ignored one. In a run of three writes on consecutive cycles, only the first one is accepted.
- R8: The first write after reset is accepted, even when it lands on the first clock edge after reset is released.
- R9: Data bits 6 down to 1 have no effect on any register.
- R10: After a commit, the staging register and the bit counter start empty, so the next commit again needs five fresh accepted bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | CPU cycle clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Write strobe, one cycle per CPU write |
| sel_i | input | 2 | Register select, taken from CPU address bits 14:13 |
| data_i | input | 8 | CPU data bus |
| ctrl_o | output | 5 | Control register |
| chr_a_o | output | 5 | Character bank register A |
| chr_b_o | output | 5 | Character bank register B |
| prg_o | output | 5 | Program bank register |

## Verification
The bench places pairs and triples of writes on consecutive cycles at points in the middle of a load. If a design shifted the dummy write, it would commit one write early and with the wrong bits. If a design failed to restart the gap timer on an ignored write, a triple would shift two bits instead of one. A write on the first edge after reset catches a gap timer that starts empty and rejects that write. An abort in the middle of a load shows whether the staging register is cleared or left stale. The abort carries bit 0 set, which catches a design that commits on an abort. A load whose select changes on its last write shows whether the target comes from the fifth write, and bits 6 to 1 are toggled throughout to expose a wrong bit pick.

// File: rtl/srl_pkg.sv
package srl_pkg;
  localparam int unsigned NUM_REGS = 4;
  localparam int unsigned SEL_W    = $clog2(NUM_REGS);

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL  = 2'b00,
    SEL_CHR_A = 2'b01,
    SEL_CHR_B = 2'b10,
    SEL_PRG   = 2'b11
  } reg_sel_e;
endpackage

// File: rtl/srl_write_gate.sv
// Accepts a write only if at least GAP cycles have elapsed since the last write.
module srl_write_gate #(
  parameter int unsigned GAP = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  output logic accept_o
);
  localparam int unsigned CNT_W = $clog2(GAP + 1);
  localparam logic [CNT_W-1:0] GAP_V = CNT_W'(GAP);

  logic [CNT_W-1:0] since_q;

  // Starts saturated so the first write after reset passes.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q <= GAP_V;
    end else if (wr_i) begin
      since_q <= CNT_W'(1);
    end else if (since_q < GAP_V) begin
      since_q <= since_q + CNT_W'(1);
    end
  end

  assign accept_o = wr_i && (since_q >= GAP_V);
endmodule

// File: rtl/srl_serial_loader.sv
module srl_serial_loader #(
  parameter int unsigned REG_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic             bit_i,
  input  logic             abort_i,
  output logic             commit_o,
  output logic             abort_o,
  output logic [REG_W-1:0] value_o
);
  localparam int unsigned CNT_W = $clog2(REG_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(REG_W - 1);

  logic [REG_W-1:0] stage_q, stage_nx;
  logic [CNT_W-1:0] cnt_q;
  logic             shift_en;

  assign shift_en = accept_i && !abort_i;
  assign stage_nx = {bit_i, stage_q[REG_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      cnt_q   <= '0;
    end else if (accept_i && abort_i) begin
      stage_q <= '0;
      cnt_q   <= '0;
    end else if (shift_en) begin
      if (cnt_q == LAST) begin
        stage_q <= '0;
        cnt_q   <= '0;
      end else begin
        stage_q <= stage_nx;
        cnt_q   <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign commit_o = shift_en && (cnt_q == LAST);
  assign abort_o  = accept_i && abort_i;
  assign value_o  = stage_nx;
endmodule

// File: rtl/srl_reg_bank.sv
module srl_reg_bank
  import srl_pkg::*;
#(
  parameter int unsigned      REG_W     = 5,
  parameter logic [REG_W-1:0] CTRL_INIT = 5'h0C,
  parameter logic [REG_W-1:0] CTRL_OR   = 5'h0C
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             commit_i,
  input  logic                             abort_i,
  input  logic [SEL_W-1:0]                 sel_i,
  input  logic [REG_W-1:0]                 value_i,
  output logic [NUM_REGS-1:0][REG_W-1:0]   regs_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [REG_W-1:0] INIT = (g == int'(SEL_CTRL)) ? CTRL_INIT : '0;
    logic [REG_W-1:0] r_q;
    logic             hit;

    assign hit = commit_i && (sel_i == SEL_W'(g));

    if (g == int'(SEL_CTRL)) begin : g_ctrl
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      r_q <= INIT;
        else if (abort_i) r_q <= r_q | CTRL_OR;
        else if (hit)     r_q <= value_i;
      end
    end else begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  r_q <= INIT;
        else if (hit) r_q <= value_i;
      end
    end

    assign regs_o[g] = r_q;
  end
endmodule

// File: rtl/serial_reg_loader.sv
module serial_reg_loader
  import srl_pkg::*;
#(
  parameter int unsigned      REG_W     = 5,
  parameter int unsigned      DATA_W    = 8,
  parameter int unsigned      GAP       = 2,
  parameter logic [REG_W-1:0] CTRL_INIT = 5'h0C,
  parameter logic [REG_W-1:0] CTRL_OR   = 5'h0C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [1:0]        sel_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [REG_W-1:0]  ctrl_o,
  output logic [REG_W-1:0]  chr_a_o,
  output logic [REG_W-1:0]  chr_b_o,
  output logic [REG_W-1:0]  prg_o
);
  localparam int unsigned ABORT_BIT = DATA_W - 1;

  logic                           accept;
  logic                           commit;
  logic                           abort;
  logic [REG_W-1:0]               value;
  logic [NUM_REGS-1:0][REG_W-1:0] regs;
  logic                           unused_data;

  assign unused_data = ^data_i[ABORT_BIT-1:1];

  srl_write_gate #(.GAP(GAP)) gate_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_i),
    .accept_o (accept)
  );

  srl_serial_loader #(.REG_W(REG_W)) loader_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .bit_i    (data_i[0]),
    .abort_i  (data_i[ABORT_BIT]),
    .commit_o (commit),
    .abort_o  (abort),
    .value_o  (value)
  );

  srl_reg_bank #(
    .REG_W     (REG_W),
    .CTRL_INIT (CTRL_INIT),
    .CTRL_OR   (CTRL_OR)
  ) bank_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (commit),
    .abort_i  (abort),
    .sel_i    (sel_i),
    .value_i  (value),
    .regs_o   (regs)
  );

  assign ctrl_o  = regs[SEL_CTRL];
  assign chr_a_o = regs[SEL_CHR_A];
  assign chr_b_o = regs[SEL_CHR_B];
  assign prg_o   = regs[SEL_PRG];
endmodule

// File: rtl/srl_checker.sv
module srl_checker #(
  parameter int unsigned REG_W  = 5,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [DATA_W-1:0] data_i,
  input logic [REG_W-1:0]  ctrl_o,
  input logic [REG_W-1:0]  chr_a_o,
  input logic [REG_W-1:0]  chr_b_o,
  input logic [REG_W-1:0]  prg_o
);
  logic wr_q, seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      wr_q   <= wr_i;
      seen_q <= 1'b1;
    end
  end

  // R6: write right after a write leaves every register untouched
  a_r6_dummy_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && wr_q |=> $stable(ctrl_o) && $stable(chr_a_o) && $stable(chr_b_o) && $stable(prg_o));

  // R5: accepted abort sets control mode bits, others untouched
  a_r5_abort_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !wr_q && data_i[DATA_W-1] |=>
      ctrl_o[3:2] == 2'b11 && $stable(ctrl_o[4]) && $stable(ctrl_o[1:0]) &&
      $stable(chr_a_o) && $stable(chr_b_o) && $stable(prg_o));

  // R4: nothing changes without a write
  a_r4_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(ctrl_o) && $stable(chr_a_o) && $stable(chr_b_o) && $stable(prg_o));

  // R3: at most one register changes per cycle
  a_r3_one_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> $countones({ctrl_o != $past(ctrl_o), chr_a_o != $past(chr_a_o),
                           chr_b_o != $past(chr_b_o), prg_o != $past(prg_o)}) <= 1);
endmodule

bind serial_reg_loader srl_checker #(.REG_W(REG_W), .DATA_W(DATA_W)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_i    (wr_i),
  .data_i  (data_i),
  .ctrl_o  (ctrl_o),
  .chr_a_o (chr_a_o),
  .chr_b_o (chr_b_o),
  .prg_o   (prg_o)
);

// File: tb/serial_reg_loader_tb_top.sv
`timescale 1ns/1ps
module serial_reg_loader_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0;
  logic [1:0] sel = 2'b00;
  logic [7:0] din = 8'h00;
  logic [4:0] ctrl, chr_a, chr_b, prg;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  serial_reg_loader dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .sel_i(sel), .data_i(din),
    .ctrl_o(ctrl), .chr_a_o(chr_a), .chr_b_o(chr_b), .prg_o(prg)
  );

  task automatic chk(input string req, input string what, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic [4:0] c, input logic [4:0] a,
                         input logic [4:0] b, input logic [4:0] p);
    chk(req, "ctrl", ctrl, c);
    chk(req, "chr_a", chr_a, a);
    chk(req, "chr_b", chr_b, b);
    chk(req, "prg", prg, p);
  endtask

  // one isolated write; returns at the negedge after the capturing edge
  task automatic put(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; sel = s; din = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic put_bit(input logic [1:0] s, input logic b, input logic [5:0] junk);
    put(s, {1'b0, junk, b});
  endtask

  task automatic t_reset_first_load;
    logic [4:0] v = 5'h16;
    chk_all("R1", 5'h0C, 5'h00, 5'h00, 5'h00);
    @(negedge clk); rst_n = 1'b1; wr = 1'b1; sel = 2'b01; din = {7'h00, v[0]};
    @(negedge clk); wr = 1'b0;
    for (int i = 1; i < 4; i++) put_bit(2'b01, v[i], 6'h00);
    chk("R4", "chr_a after four bits", chr_a, 5'h00);
    put_bit(2'b01, v[4], 6'h00);
    chk("R8", "chr_a commit with first-edge write", chr_a, v);
    chk("R2", "ctrl untouched", ctrl, 5'h0C);
  endtask

  task automatic load5(input logic [1:0] s, input logic [4:0] v, input logic [5:0] junk);
    for (int i = 0; i < 5; i++) put_bit(s, v[i], junk);
  endtask

  task automatic t_targets;
    load5(2'b00, 5'h13, 6'h3F);
    chk("R9", "ctrl with junk bits", ctrl, 5'h13);
    load5(2'b10, 5'h0A, 6'h2A);
    chk("R3", "chr_b", chr_b, 5'h0A);
    load5(2'b11, 5'h1E, 6'h15);
    chk_all("R3", 5'h13, 5'h16, 5'h0A, 5'h1E);
    for (int i = 0; i < 4; i++) put_bit(2'b10, 1'b1, 6'h00);
    chk("R10", "chr_b after four fresh bits", chr_b, 5'h0A);
    put_bit(2'b10, 1'b0, 6'h00);
    chk("R10", "chr_b fresh commit", chr_b, 5'h0F);
  endtask

  task automatic t_split_sel;
    logic [4:0] v = 5'h05;
    for (int i = 0; i < 4; i++) put_bit(2'b00, v[i], 6'h00);
    put_bit(2'b11, v[4], 6'h00);
    chk("R3", "prg from fifth-write select", prg, 5'h05);
    chk("R3", "ctrl not target", ctrl, 5'h13);
  endtask

  task automatic b2b(input logic [1:0] s, input logic [7:0] d1, input logic [7:0] d2);
    @(negedge clk); wr = 1'b1; sel = s; din = d1;
    @(negedge clk); din = d2;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic t_back_to_back;
    b2b(2'b10, 8'h01, 8'h00);
    for (int i = 0; i < 3; i++) put_bit(2'b10, 1'b0, 6'h00);
    chk("R6", "chr_b before true fifth bit", chr_b, 5'h0F);
    put_bit(2'b10, 1'b1, 6'h00);
    chk("R6", "chr_b dummy bit dropped", chr_b, 5'h11);
    b2b(2'b01, 8'h01, 8'h80);
    chk("R6", "ignored abort leaves ctrl", ctrl, 5'h13);
    put_bit(2'b01, 1'b0, 6'h00);
    put_bit(2'b01, 1'b1, 6'h00);
    put_bit(2'b01, 1'b0, 6'h00);
    put_bit(2'b01, 1'b0, 6'h00);
    chk("R6", "chr_a load survives ignored abort", chr_a, 5'h05);
  endtask

  task automatic t_triple;
    @(negedge clk); wr = 1'b1; sel = 2'b11; din = 8'h01;
    @(negedge clk); din = 8'h01;
    @(negedge clk); din = 8'h01;
    @(negedge clk); wr = 1'b0;
    for (int i = 0; i < 3; i++) put_bit(2'b11, 1'b0, 6'h00);
    chk("R7", "prg before fifth accepted", prg, 5'h05);
    put_bit(2'b11, 1'b0, 6'h00);
    chk("R7", "prg only first of triple", prg, 5'h01);
  endtask

  task automatic t_abort;
    for (int i = 0; i < 3; i++) put_bit(2'b01, 1'b1, 6'h00);
    put(2'b10, 8'h81);
    chk_all("R5", 5'h1F, 5'h05, 5'h11, 5'h01);
    put_bit(2'b01, 1'b0, 6'h00);
    put_bit(2'b01, 1'b1, 6'h00);
    put_bit(2'b01, 1'b0, 6'h00);
    put_bit(2'b01, 1'b1, 6'h00);
    chk("R5", "chr_a after four post-abort bits", chr_a, 5'h05);
    put_bit(2'b01, 1'b0, 6'h00);
    chk("R5", "chr_a clean reload", chr_a, 5'h0A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_first_load();
    t_targets();
    t_split_sel();
    t_back_to_back();
    t_triple();
    t_abort();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule